// File: doc/BRIEF.md
# Transverse Damper Feedback Filter

A streaming filter for one plane of a transverse beam feedback loop. Signed converter samples arrive with a valid strobe. Each sample is first smoothed by a four-sample running average, which suppresses the bunch-frequency lines. A comb then subtracts the smoothed value from exactly one machine turn earlier, which removes everything locked to the revolution frequency. The difference is scaled by a programmable signed gain, saturated to the output width, and held back by a programmable number of clock cycles so that the kick lands on the same bunch one turn later. The result drives an offset-binary DAC word.

A watchdog observes the reference RF clock, sampled into the system clock domain. If no edge is seen for longer than a programmable timeout, a sticky error flag is raised and the output is forced to the DAC mid-code. The same mid-code is driven while the filter is disabled and while the one-turn history is still filling after reset.

Top module: `damper_filter`

## Requirements
- R1: The smoothed value of sample n is floor((x[n]+x[n-1]+x[n-2]+x[n-3])/4), where samples before the first one after reset count as 0 and only strobed samples (in_valid high) enter the history.
- R2: The comb output of sample n is the smoothed value of sample n minus the smoothed value of sample n-TURN_LEN, counted in strobed samples.
- R3: While fewer than TURN_LEN samples have been received since reset, any sample that reaches the output drives the mid-code 2^(OUT_W-1).
- R4: The comb output is multiplied by gain (signed, GAIN_FRAC fraction bits), shifted right arithmetically by GAIN_FRAC (floor) and clamped to [-2^(OUT_W-1), 2^(OUT_W-1)-1]; the result is sent as offset binary (value + 2^(OUT_W-1)).
- R5: A sample strobed at clock edge k appears on dac_out at edge k+2+D, where D is the delay register (0 to 2^DLY_W-1); the gain applied is the register value held before edge k+1, D the value held before edge k+2+D.
- R6: While enable is low, dac_out is the mid-code one edge later.
- R7: When the cycle count since the last seen edge of rf_ref exceeds the timeout register, rf_err is set and dac_out is the mid-code from the next edge on.
- R8: rf_err stays set until err_clr is asserted in a cycle without a loss condition; a clear in the same cycle as a loss condition leaves it set.
- R9: dac_valid is high for exactly the edges at which a strobed sample reaches the output; between them dac_out holds its value unless forced to mid-code.
- R10: After reset dac_out is the mid-code, dac_valid and rf_err are low, the gain is 1.0, the delay is 0 and the timeout is TO_RESET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Feedback output enable |
| in_valid | input | 1 | Sample strobe |
| in_data | input | IN_W | Signed converter sample |
| rf_ref | input | 1 | Reference RF clock, asynchronous |
| gain_wr | input | 1 | Write strobe for the gain register |
| gain_in | input | GAIN_W | Signed gain, GAIN_FRAC fraction bits |
| delay_wr | input | 1 | Write strobe for the delay register |
| delay_in | input | DLY_W | Output delay in clock cycles |
| timeout_wr | input | 1 | Write strobe for the timeout register |
| timeout_in | input | TO_W | Clock-loss timeout in cycles |
| err_clr | input | 1 | Clears the clock-loss flag |
| dac_out | output | OUT_W | Offset-binary DAC word |
| dac_valid | output | 1 | A filtered sample is on dac_out |
| rf_err | output | 1 | Sticky clock-loss flag |

## Verification
The clock-loss detection and the software clear of rf_err can meet in one cycle. The bench stops the reference clock until the loss condition holds and pulses err_clr while it still holds, expecting the flag to stay set; after the clock resumes a second clear must drop it. A cycle-accurate reference model computes the expected flag and the forced mid-code output for every edge, so the outcome of the collision is judged on both outputs.

// File: rtl/damper_filter.sv
module damper_filter #(
  parameter int IN_W      = 14,
  parameter int OUT_W     = 14,
  parameter int TURN_LEN  = 2352,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 8,
  parameter int DLY_W     = 4,
  parameter int TO_W      = 12,
  parameter int TO_RESET  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     in_valid,
  input  logic signed [IN_W-1:0]   in_data,
  input  logic                     rf_ref,
  input  logic                     gain_wr,
  input  logic signed [GAIN_W-1:0] gain_in,
  input  logic                     delay_wr,
  input  logic [DLY_W-1:0]         delay_in,
  input  logic                     timeout_wr,
  input  logic [TO_W-1:0]          timeout_in,
  input  logic                     err_clr,
  output logic [OUT_W-1:0]         dac_out,
  output logic                     dac_valid,
  output logic                     rf_err
);
  localparam int PTR_W = $clog2(TURN_LEN);
  localparam int NW    = IN_W + 1;
  localparam int PW    = NW + GAIN_W;
  localparam int WW    = OUT_W + 2;
  localparam int DEPTH = 1 << DLY_W;
  localparam logic [OUT_W-1:0] MID = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic signed [GAIN_W-1:0] UNITY = GAIN_W'(1 << GAIN_FRAC);
  localparam logic signed [PW-1:0] SMAX = {{(PW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [PW-1:0] SMIN = ~SMAX;

  logic signed [IN_W-1:0]   h1, h2, h3;
  logic signed [IN_W+1:0]   sum4;
  logic signed [IN_W-1:0]   box;
  logic signed [IN_W-1:0]   turn_mem [TURN_LEN];
  logic [PTR_W-1:0]         wptr, fill_cnt;
  logic                     fill_done;
  logic signed [NW-1:0]     notch_d, notch_q;
  logic                     n_ok, n_v;
  logic signed [GAIN_W-1:0] gain_r;
  logic [DLY_W-1:0]         dsel;
  logic signed [PW-1:0]     prod, scaled;
  logic signed [OUT_W-1:0]  sat_d;
  logic [WW-1:0]            g_word, tap;
  logic [WW-1:0]            dly [DEPTH];
  logic                     rs1, rs2, rs3;
  logic [TO_W-1:0]          wd_cnt, timeout_r;
  logic                     loss;

  // boxcar over the current sample and three held ones, then the one-turn comb
  assign sum4    = (IN_W+2)'(in_data) + (IN_W+2)'(h1) + (IN_W+2)'(h2) + (IN_W+2)'(h3);
  assign box     = sum4[IN_W+1:2];
  assign notch_d = NW'(box) - NW'(turn_mem[wptr]);

  always_ff @(posedge clk) if (in_valid) turn_mem[wptr] <= box;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {h1, h2, h3} <= '0;
      wptr <= '0; fill_cnt <= '0; fill_done <= 1'b0;
      notch_q <= '0; n_ok <= 1'b0; n_v <= 1'b0;
    end else begin
      n_v <= in_valid;
      if (in_valid) begin
        h3 <= h2; h2 <= h1; h1 <= in_data;
        wptr <= (wptr == PTR_W'(TURN_LEN-1)) ? '0 : wptr + PTR_W'(1);
        notch_q <= notch_d;
        n_ok <= fill_done;
        if (!fill_done) begin
          fill_cnt <= fill_cnt + PTR_W'(1);
          if (fill_cnt == PTR_W'(TURN_LEN-1)) fill_done <= 1'b1;
        end
      end
    end
  end

  // gain and saturation
  assign prod   = PW'(notch_q) * PW'(gain_r);
  assign scaled = prod >>> GAIN_FRAC;
  assign sat_d  = (scaled > SMAX) ? SMAX[OUT_W-1:0] :
                  (scaled < SMIN) ? SMIN[OUT_W-1:0] : scaled[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_word <= '0; gain_r <= UNITY; dsel <= '0; timeout_r <= TO_W'(TO_RESET);
    end else begin
      g_word <= {n_v, n_ok, sat_d};
      if (gain_wr)    gain_r    <= gain_in;
      if (delay_wr)   dsel      <= delay_in;
      if (timeout_wr) timeout_r <= timeout_in;
    end
  end

  // programmable delay line, shifted every clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) dly[i] <= '0;
    end else begin
      dly[0] <= g_word;
      for (int i = 1; i < DEPTH; i++) dly[i] <= dly[i-1];
    end
  end

  assign tap = (dsel == '0) ? g_word : dly[dsel - DLY_W'(1)];

  // RF clock watchdog
  assign loss = wd_cnt > timeout_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {rs1, rs2, rs3} <= '0; wd_cnt <= '0; rf_err <= 1'b0;
    end else begin
      rs1 <= rf_ref; rs2 <= rs1; rs3 <= rs2;
      if (rs2 != rs3)   wd_cnt <= '0;
      else if (!(&wd_cnt)) wd_cnt <= wd_cnt + TO_W'(1);
      rf_err <= loss | (rf_err & ~err_clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_out <= MID; dac_valid <= 1'b0;
    end else begin
      dac_valid <= tap[WW-1];
      if (!enable || rf_err)  dac_out <= MID;
      else if (tap[WW-1])     dac_out <= tap[WW-2] ? {~tap[OUT_W-1], tap[OUT_W-2:0]} : MID;
    end
  end

  assert_fill_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_done |=> dac_out == MID);
  assert_off_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> dac_out == MID);
  assert_err_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_err |=> dac_out == MID);
  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rf_err) |-> $past(wd_cnt) > $past(timeout_r));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_err && !err_clr |=> rf_err);
endmodule

// File: tb/damper_filter_test.sv
module damper_filter_test;
  localparam int IN_W = 10, OUT_W = 10, TL = 16, GW = 12, GF = 6, DW = 3, TW = 8, TOR = 20;
  localparam int MIDV = 1 << (OUT_W-1);

  logic clk = 0, rst_n = 0, enable = 0, in_valid = 0, rf_ref = 0;
  logic signed [IN_W-1:0] in_data = '0;
  logic gain_wr = 0, delay_wr = 0, timeout_wr = 0, err_clr = 0;
  logic signed [GW-1:0] gain_in = '0;
  logic [DW-1:0] delay_in = '0;
  logic [TW-1:0] timeout_in = '0;
  logic [OUT_W-1:0] dac_out;
  logic dac_valid, rf_err;

  damper_filter #(.IN_W(IN_W), .OUT_W(OUT_W), .TURN_LEN(TL), .GAIN_W(GW), .GAIN_FRAC(GF),
                  .DLY_W(DW), .TO_W(TW), .TO_RESET(TOR)) uut (.*);

  always #2 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0, nsamp = 0;
  int xs[8192]; bit va[8192]; int ni[8192]; int gb[8192]; bit rfh[8192];
  int m_gain = 1 << GF, m_dly = 0, m_to = TOR, m_cnt = 0, m_out = MIDV;
  bit m_err = 0, m_val = 0, rf_run = 0;
  string tag = "R10";

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", t, cyc, act, exp);
    end
  endtask

  function automatic int boxv(int k);
    int s = 0;
    for (int j = 0; j < 4; j++) if (k - j >= 0) s += xs[k-j];
    return s >>> 2;
  endfunction

  function automatic int filt(int n, int g);
    longint p = longint'(boxv(n) - boxv(n - TL)) * g;
    p = p >>> GF;
    if (p > MIDV - 1) p = MIDV - 1;
    if (p < -MIDV) p = -MIDV;
    return int'(p);
  endfunction

  task automatic tick();
    int s; bit tog, nerr, tv;
    if (rf_run && (cyc % 2 == 1)) rf_ref = ~rf_ref;
    cyc++;
    va[cyc] = in_valid; ni[cyc] = nsamp; gb[cyc] = m_gain; rfh[cyc] = rf_ref;
    if (in_valid) begin xs[nsamp] = int'(in_data); nsamp++; end
    tog  = (cyc >= 2 ? rfh[cyc-2] : 1'b0) != (cyc >= 3 ? rfh[cyc-3] : 1'b0);
    nerr = (m_cnt > m_to) || (m_err && !err_clr);
    s  = cyc - 2 - m_dly;
    tv = (s >= 1) && va[s];
    if (!enable || m_err) m_out = MIDV;
    else if (tv) m_out = (ni[s] >= TL) ? filt(ni[s], gb[s+1]) + MIDV : MIDV;
    m_val = tv;
    m_cnt = tog ? 0 : (m_cnt < 255 ? m_cnt + 1 : 255);
    m_err = nerr;
    if (gain_wr) m_gain = int'(gain_in);
    if (delay_wr) m_dly = int'(delay_in);
    if (timeout_wr) m_to = int'(timeout_in);
    @(posedge clk); #1;
    chk(tag, int'(dac_out), m_out);
    chk("R9", int'(dac_valid), int'(m_val));
    chk(m_err ? "R7" : "R8", int'(rf_err), int'(m_err));
  endtask

  function automatic int pat(int kind, int i);
    case (kind)
      0: return i * 7 - 60;
      1: return ((i / 4) % 2) ? -400 : 400;
      2: return int'($urandom_range(0, 1000)) - 500;
      default: return (i % 2) ? 255 : -256;
    endcase
  endfunction

  task automatic stream(int n, int kind, int gap);
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = IN_W'(pat(kind, i)); tick();
      in_valid = 0;
      for (int k = 0; k < gap; k++) tick();
    end
    in_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10", int'(dac_out), MIDV);
    chk("R10", int'(dac_valid), 0);
    chk("R10", int'(rf_err), 0);
    rst_n = 1; enable = 1; rf_run = 1;
    idle(3);
    tag = "R3"; stream(TL, 0, 0); idle(4);
    tag = "R1"; stream(20, 3, 0); stream(12, 2, 0); idle(4);
    tag = "R2"; stream(24, 2, 1); stream(10, 0, 2); idle(4);
    tag = "R4"; gain_wr = 1; gain_in = GW'(256); tick(); gain_wr = 0;
    stream(24, 1, 0);
    gain_wr = 1; gain_in = -GW'(96); tick(); gain_wr = 0;
    stream(20, 2, 0); idle(4);
    tag = "R5"; delay_wr = 1; delay_in = 3'd5; tick(); delay_wr = 0;
    stream(14, 2, 0); idle(10);
    delay_wr = 1; delay_in = 3'd7; tick(); delay_wr = 0;
    stream(10, 2, 1);
    delay_wr = 1; delay_in = 3'd2; tick(); delay_wr = 0;
    stream(8, 0, 0); idle(10);
    tag = "R6"; in_valid = 1;
    for (int i = 0; i < 12; i++) begin
      enable = !(i >= 4 && i < 9);
      in_data = IN_W'(pat(2, i)); tick();
    end
    in_valid = 0; enable = 1; idle(10);
    tag = "R7"; timeout_wr = 1; timeout_in = 8'd10; tick(); timeout_wr = 0;
    rf_run = 0; stream(20, 2, 0);
    tag = "R8"; err_clr = 1; tick(); err_clr = 0;
    stream(6, 2, 0);
    rf_run = 1; idle(6);
    err_clr = 1; tick(); err_clr = 0;
    stream(16, 2, 0); idle(12);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule